// File: doc/BRIEF.md
# Fixed-Latency Floating-Point Operation Sequencer

This block is the control shell around a four-operation floating-point unit. A caller presents two 64-bit operands, a 2-bit operation code and a 2-bit rounding mode, then raises `enable` for two clock cycles. On the first cycle that `enable` is high, the sequencer copies all of those inputs into holding registers. It also sends a one-cycle start pulse to the arithmetic unit chosen by the code.

From that point the sequencer counts a fixed number of cycles. The count depends on the operation: addition is the shortest and division the longest. When the count ends, it takes the result word and the exception flags from the arithmetic units and raises `ready`. The captured result and flags stay on the outputs, and `ready` stays high, until the next rising edge of `enable` begins another operation. The arithmetic units themselves lie outside this block. They read the held operands and rounding mode from the `unit*` outputs.

Top module: `opSequencer`

## Requirements
- R1: A synchronous reset clears `ready`, `result`, `flags` and `unitStart` to zero.
- R2: `opA`, `opB`, `opcode` and `roundMode` are sampled only at the clock edge where `enable` is first seen high after being low. Later changes to them have no effect on `unitOpA`, `unitOpB`, `unitRound` or the final result.
- R3: In the cycle after that edge, exactly one bit of `unitStart` is high, for one cycle. The bit index equals the opcode: 00 = add (bit 0), 01 = subtract (bit 1), 10 = multiply (bit 2), 11 = divide (bit 3).
- R4: `ready` rises at the L-th clock edge after the edge where `enable` was first sampled high. L is 20 for add, 21 for subtract, 24 for multiply and 71 for divide.
- R5: `result` and `flags` take the values of `unitResult` and `unitFlags` sampled at the same edge where `ready` rises.
- R6: While `ready` is high, `result` and `flags` hold their values, and changes on `unitResult` and `unitFlags` are ignored.
- R7: `ready` stays high until the next rising edge of `enable`. It is low in the cycle after that edge.
- R8: Keeping `enable` high for longer than two cycles starts nothing new; only a low-to-high transition starts an operation.
- R9: A rising edge of `enable` while an operation is still counting abandons it and starts the new operation with the new operation's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Start request; its rising edge begins an operation |
| opcode | input | 2 | Operation select (00 add, 01 sub, 10 mul, 11 div) |
| roundMode | input | MODE_W (2) | Rounding mode passed to the arithmetic units |
| opA | input | DATA_W (64) | First operand |
| opB | input | DATA_W (64) | Second operand |
| unitStart | output | 4 | One-cycle start pulse, one bit per arithmetic unit |
| unitOpA | output | DATA_W (64) | Held first operand |
| unitOpB | output | DATA_W (64) | Held second operand |
| unitRound | output | MODE_W (2) | Held rounding mode |
| unitResult | input | DATA_W (64) | Result word from the arithmetic units |
| unitFlags | input | FLAG_W (5) | Exception flags from the arithmetic units |
| ready | output | 1 | High once the result is valid, until the next start |
| result | output | DATA_W (64) | Captured result |
| flags | output | FLAG_W (5) | Captured exception flags |

## Verification
The following are checked on every cycle:
- The start pulse is one-hot and its bit matches the opcode sampled one edge earlier.
- The held operand matches the operand sampled at that edge.
- `ready` is low whenever a start pulse is out.
- `result` and `flags` do not move while `ready` stays high.
- Reset clears the outputs.

Some behaviour can only be shown by the bench's scenarios:
- The exact cycle count per opcode.
- That the captured word is the arithmetic units' value at completion.
- That a long `enable` hold does not restart.
- That a mid-flight restart takes the new opcode's latency.

The bench's delayed unit models drive a garbage word until one cycle before completion, so a capture that comes one cycle early is visible in `result`.

// File: rtl/seqPkg.sv
package seqPkg;

  localparam int NUM_OPS = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } opKind_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // latch inputs and pulse unit start
    logic finish;    // take result and flags from the units
  } seqStrobe_t;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
#(
  parameter int LAT_ADD = 20,
  parameter int LAT_SUB = 21,
  parameter int LAT_MUL = 24,
  parameter int LAT_DIV = 71
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] opcode,
  output logic       ready,
  output seqStrobe_t strobe
);

  localparam int LAT_MAX_AS = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
  localparam int LAT_MAX_MD = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LAT_MAX    = (LAT_MAX_AS > LAT_MAX_MD) ? LAT_MAX_AS : LAT_MAX_MD;
  localparam int CNT_W      = $clog2(LAT_MAX + 1);

  logic             enablePrev;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] selLat;
  logic             rise;
  logic             done;

  assign rise = enable & ~enablePrev;
  assign done = busy & (cnt == target);

  always_comb begin
    case (opKind_e'(opcode))
      OP_ADD:  selLat = CNT_W'(LAT_ADD);
      OP_SUB:  selLat = CNT_W'(LAT_SUB);
      OP_MUL:  selLat = CNT_W'(LAT_MUL);
      default: selLat = CNT_W'(LAT_DIV);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enablePrev <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      target     <= '0;
      ready      <= 1'b0;
    end else begin
      enablePrev <= enable;
      if (rise) begin
        // The edge that sees enable high is cycle one of the latency
        busy   <= 1'b1;
        cnt    <= CNT_W'(1);
        target <= selLat;
        ready  <= 1'b0;
      end else if (busy) begin
        if (done) begin
          busy  <= 1'b0;
          ready <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign strobe.capture = rise;
  assign strobe.finish  = done & ~rise;

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 5,
  parameter int MODE_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobe_t          strobe,
  input  logic [1:0]          opcode,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [MODE_W-1:0]   roundMode,
  input  logic [DATA_W-1:0]   unitResult,
  input  logic [FLAG_W-1:0]   unitFlags,
  output logic [NUM_OPS-1:0]  unitStart,
  output logic [DATA_W-1:0]   unitOpA,
  output logic [DATA_W-1:0]   unitOpB,
  output logic [MODE_W-1:0]   unitRound,
  output logic [DATA_W-1:0]   result,
  output logic [FLAG_W-1:0]   flags
);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_start
    always_ff @(posedge clk) begin
      if (rst) unitStart[i] <= 1'b0;
      else     unitStart[i] <= strobe.capture && (opcode == 2'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unitOpA   <= '0;
      unitOpB   <= '0;
      unitRound <= '0;
    end else if (strobe.capture) begin
      unitOpA   <= opA;
      unitOpB   <= opB;
      unitRound <= roundMode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.finish) begin
      result <= unitResult;
      flags  <= unitFlags;
    end
  end

endmodule

// File: rtl/opSequencer.sv
module opSequencer
  import seqPkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FLAG_W  = 5,
  parameter int MODE_W  = 2,
  parameter int LAT_ADD = 20,
  parameter int LAT_SUB = 21,
  parameter int LAT_MUL = 24,
  parameter int LAT_DIV = 71
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        opcode,
  input  logic [MODE_W-1:0] roundMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [3:0]        unitStart,
  output logic [DATA_W-1:0] unitOpA,
  output logic [DATA_W-1:0] unitOpB,
  output logic [MODE_W-1:0] unitRound,
  input  logic [DATA_W-1:0] unitResult,
  input  logic [FLAG_W-1:0] unitFlags,
  output logic              ready,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  seqStrobe_t strobe;

  seqControl #(
    .LAT_ADD(LAT_ADD), .LAT_SUB(LAT_SUB), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .opcode (opcode),
    .ready  (ready),
    .strobe (strobe)
  );

  seqDatapath #(
    .DATA_W(DATA_W), .FLAG_W(FLAG_W), .MODE_W(MODE_W)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .opcode     (opcode),
    .opA        (opA),
    .opB        (opB),
    .roundMode  (roundMode),
    .unitResult (unitResult),
    .unitFlags  (unitFlags),
    .unitStart  (unitStart),
    .unitOpA    (unitOpA),
    .unitOpB    (unitOpB),
    .unitRound  (unitRound),
    .result     (result),
    .flags      (flags)
  );

endmodule

// File: rtl/opSequencerChk.sv
module opSequencerChk #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        opcode,
  input logic [DATA_W-1:0] opA,
  input logic [3:0]        unitStart,
  input logic [DATA_W-1:0] unitOpA,
  input logic              ready,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ready && unitStart == 4'b0000 && result == '0 && flags == '0));

  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unitStart));

  // R3
  start_code_chk: assert property (@(posedge clk) disable iff (rst)
    (unitStart != 4'b0000) |-> (unitStart == (4'b0001 << $past(opcode))));

  // R2
  operand_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (unitStart != 4'b0000) |-> (unitOpA == $past(opA)));

  // R7
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (unitStart != 4'b0000) |-> !ready);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> ($stable(result) && $stable(flags)));

endmodule

bind opSequencer opSequencerChk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .opA       (opA),
  .unitStart (unitStart),
  .unitOpA   (unitOpA),
  .ready     (ready),
  .result    (result),
  .flags     (flags)
);

// File: tb/test_opSequencer.sv
module test_opSequencer;

  localparam int DATA_W = 64;
  localparam int FLAG_W = 5;
  localparam int MODE_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic [1:0]        opcode = 2'b00;
  logic [MODE_W-1:0] roundMode = '0;
  logic [DATA_W-1:0] opA = '0;
  logic [DATA_W-1:0] opB = '0;
  logic [3:0]        unitStart;
  logic [DATA_W-1:0] unitOpA, unitOpB;
  logic [MODE_W-1:0] unitRound;
  logic [DATA_W-1:0] unitResult;
  logic [FLAG_W-1:0] unitFlags;
  logic              ready;
  logic [DATA_W-1:0] result;
  logic [FLAG_W-1:0] flags;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  opSequencer i_opSequencer (
    .clk(clk), .rst(rst), .enable(enable), .opcode(opcode), .roundMode(roundMode),
    .opA(opA), .opB(opB), .unitStart(unitStart), .unitOpA(unitOpA), .unitOpB(unitOpB),
    .unitRound(unitRound), .unitResult(unitResult), .unitFlags(unitFlags),
    .ready(ready), .result(result), .flags(flags)
  );

  // Reference behaviour
  function automatic logic [DATA_W-1:0] refModel(input logic [1:0] op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a * b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic int expLat(input logic [1:0] op);
    case (op)
      2'd0:    return 20;
      2'd1:    return 21;
      2'd2:    return 24;
      default: return 71;
    endcase
  endfunction

  // Delayed unit models: garbage until one cycle before completion
  logic [6:0] stubCnt;
  logic [1:0] stubOp;
  logic [1:0] startIdx;
  bit         garble = 1'b0;

  always_comb begin
    startIdx = 2'd0;
    for (int i = 0; i < 4; i++) if (unitStart[i]) startIdx = 2'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stubCnt <= '0;
      stubOp  <= '0;
    end else if (unitStart != 4'b0000) begin
      stubCnt <= 7'd1;
      stubOp  <= startIdx;
    end else if (stubCnt != 7'd127) begin
      stubCnt <= stubCnt + 7'd1;
    end
  end

  assign unitResult = (!garble && int'(stubCnt) >= expLat(stubOp) - 1)
                      ? refModel(stubOp, unitOpA, unitOpB) : 64'hBAD0_BAD0_BAD0_BAD0;
  assign unitFlags  = garble ? 5'b01010 : {1'b1, unitRound, stubOp};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Run one operation; enable held for `hold` cycles; returns measured latency
  task automatic runOp(input logic [1:0] op, input logic [1:0] rm,
                       input logic [63:0] a, input logic [63:0] b,
                       input int hold, output int lat);
    int cycles;
    @(negedge clk);
    opcode = op; roundMode = rm; opA = a; opB = b; enable = 1'b1;
    @(posedge clk);
    cycles = 0;
    @(negedge clk);
    check(ready == 1'b0, "R7 ready cleared by start", 64'(ready), 64'd0);
    check(unitStart == (4'b0001 << op), "R3 start pulse", 64'(unitStart), 64'(4'b0001 << op));
    check(unitOpA == a && unitOpB == b && unitRound == rm, "R2 operands held",
          unitOpA, a);
    opA = ~a; opB = ~b; opcode = op + 2'd1; roundMode = ~rm;
    while (!ready && cycles < 200) begin
      if (cycles == hold - 1) enable = 1'b0;
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (cycles == 1)
        check(unitStart == 4'b0000, "R3 pulse lasts one cycle", 64'(unitStart), 64'd0);
    end
    enable = 1'b0;
    lat = cycles;
  endtask

  localparam int NV = 8;
  // {opcode, roundMode, expected latency, opA, opB}
  localparam logic [138:0] VECS [NV] = '{
    {2'd0, 2'd0, 7'd20, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004},
    {2'd1, 2'd1, 7'd21, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020},
    {2'd2, 2'd2, 7'd24, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0007},
    {2'd3, 2'd3, 7'd71, 64'hF0F0_F0F0_1234_5678, 64'h0F0F_0F0F_8765_4321},
    {2'd0, 2'd3, 7'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'd2, 2'd0, 7'd24, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0002},
    {2'd1, 2'd2, 7'd21, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {2'd3, 2'd1, 7'd71, 64'hAAAA_5555_AAAA_5555, 64'h5555_AAAA_5555_AAAA}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int lat;
    logic [63:0] held;
    logic [4:0]  heldF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b0 && unitStart == 4'b0000 && result == '0 && flags == '0,
          "R1 reset state", {result[58:0], flags}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op = VECS[v][138:137];
      logic [1:0]  rm = VECS[v][136:135];
      int          el = int'(VECS[v][134:128]);
      logic [63:0] a  = VECS[v][127:64];
      logic [63:0] b  = VECS[v][63:0];
      runOp(op, rm, a, b, 2, lat);
      check(lat == el, "R4 latency", 64'(lat), 64'(el));
      check(result == refModel(op, a, b), "R5 result", result, refModel(op, a, b));
      check(flags == {1'b1, rm, op}, "R5 flags", 64'(flags), 64'({1'b1, rm, op}));
    end

    // R6 and R7: outputs hold and ready stays high while unit outputs change
    held = result; heldF = flags;
    garble = 1'b1;
    repeat (10) @(negedge clk);
    check(ready == 1'b1, "R7 ready stays high", 64'(ready), 64'd1);
    check(result == held && flags == heldF, "R6 result held", result, held);
    garble = 1'b0;

    // R8: enable held long, no restart
    runOp(2'd1, 2'd0, 64'd100, 64'd1, 6, lat);
    check(lat == 21, "R8 long hold latency", 64'(lat), 64'd21);
    runOp(2'd0, 2'd1, 64'd5, 64'd6, 30, lat);
    check(lat == 20, "R8 hold past completion", 64'(lat), 64'd20);
    repeat (15) @(negedge clk);
    check(ready == 1'b1 && result == 64'd11, "R8 no restart while held",
          result, 64'd11);

    // R9: restart in flight
    @(negedge clk);
    opcode = 2'd3; opA = 64'd9; opB = 64'd9; enable = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    enable = 1'b0;
    repeat (5) @(posedge clk);
    runOp(2'd2, 2'd2, 64'd6, 64'd7, 2, lat);
    check(lat == 24, "R9 restart latency", 64'(lat), 64'd24);
    check(result == 64'd42, "R9 restart result", result, 64'd42);
    repeat (80) @(negedge clk);
    check(ready == 1'b1 && result == 64'd42, "R9 abandoned op leaves no trace",
          result, 64'd42);

    // R1: reset in flight
    @(negedge clk);
    opcode = 2'd0; enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    enable = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(ready == 1'b0 && result == '0 && flags == '0 && unitStart == 4'b0000,
          "R1 reset mid-operation", result, 64'd0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(ready == 1'b0, "R1 no completion after reset", 64'(ready), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule